// File: doc/BRIEF.md
# Serial Bus DMA Channel Controller

This block runs one channel of a byte-serial peripheral bus and moves a block of bytes between system memory and the attached serial device. Software programs the channel through a small register window of four 32-bit words at consecutive word offsets. The four words hold the bus settings, the memory pointer, the byte count and the control word, so a single multi-word store can program all of them. A control write with the start and DMA-mode bits set launches the transfer. Software then polls control bit 0 until it reads zero.

In the memory-to-device direction, the block fetches each byte through its memory request port and shifts it out most-significant bit first. In the device-to-memory direction, it shifts in a byte while it drives zeros, then stores the byte. The chip-select lines come straight from the settings word. They therefore stay asserted across back-to-back transfers, for example an outgoing command burst followed by an incoming read of the answer.

The memory side uses valid/ready. A request (`mem_req_*`) is offered with `mem_req_valid` and is taken in the cycle where `mem_req_ready` is also high. Until then, address, write flag and write data are held unchanged. A read response is taken in a cycle where both `mem_rsp_valid` and `mem_rsp_ready` are high. `mem_rsp_ready` is high only while the block waits for the byte it asked for. The responder may stall either handshake for any number of cycles.

Top module: `sdma_chan`

## Requirements
- R1: After reset all four registers read 0, chip-select lines are all high (inactive), serial clock is low, serial data-out is low and no memory request is offered.
- R2: Register byte offsets are settings 0x14, pointer 0x18, count 0x1C and control 0x20. Control reads back as {dir[3:2], mode[1], busy[0]}. Any other offset reads 0.
- R3: A control write with bits 1:0 = 11 and bit 3 = 0 starts a transfer. Value 7 (dir 01) moves memory to the device and value 3 (dir 00) moves the device to memory. Bit 0 reads 1 from the cycle after the write until the transfer completes, and then reads 0 (7 reads back as 6).
- R4: Memory-to-device: the bytes at pointer, pointer+1, … are sent in order, MSB first, one byte per counted byte. Data-out changes only while the serial clock is low.
- R5: Device-to-memory: data-in is sampled on each rising serial clock edge, MSB first. Each assembled byte is written to pointer, pointer+1, …. Data-out stays 0 throughout the transfer.
- R6: During a memory-to-device transfer the sampled data-in bytes are discarded and no memory write request is issued.
- R7: Settings bits 6:4 = k give a serial clock period of 32 >> k system cycles (k = 0 is the slowest, 32). For k ≥ 4 the period is 2.
- R8: Chip-select line i is driven low exactly when settings bit 7+i is 1, for i = 0..2, independent of transfer state. Value 0x0880 gives cs_n = 110 and keeps it between transfers.
- R9: The pointer advances by one and the count drops by one for each byte moved. After completion they read start+length and 0.
- R10: While busy, writes to any register are ignored.
- R11: A start with count 0 reads busy for exactly one cycle and produces no serial clock edges.
- R12: A memory request held off by `mem_req_ready` low keeps valid, address, write flag and data stable until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset in the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_we | output | 1 | 1 = byte store, 0 = byte fetch |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 8 | Byte to store |
| mem_rsp_valid | input | 1 | Fetched byte is present |
| mem_rsp_ready | output | 1 | Block waits for a fetched byte |
| mem_rsp_data | input | 8 | Fetched byte |
| ser_cs_n | output | 3 | Active-low chip-select lines |
| ser_sclk | output | 1 | Serial clock, idles low |
| ser_sdo | output | 1 | Serial data to the device |
| ser_sdi | input | 1 | Serial data from the device |

## Verification
The outgoing direction runs a 128-byte block whose byte values all differ, so the order, the MSB-first packing and any pointer slip show up in the device-side capture. A different repeating byte sequence comes back in the incoming direction, which separates sampled data from stale or zero bytes and shows whether the stores land at the right addresses. The memory side stalls one cycle in three, which exposes requests that drop or change under back-pressure. Runs at two clock-rate settings, with and without chip select, and with a zero count tell the divider mapping, the chip-select decode and the empty-transfer completion apart from the normal path.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [5:0] OFF_SET = 6'h14;
  localparam logic [5:0] OFF_PTR = 6'h18;
  localparam logic [5:0] OFF_CNT = 6'h1C;
  localparam logic [5:0] OFF_CTL = 6'h20;

  typedef enum logic [1:0] {
    DIR_IN  = 2'b00,
    DIR_OUT = 2'b01
  } dir_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SHIFT,
    ST_STORE
  } state_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [5:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          step,
  input  logic          fin,
  output logic          busy,
  output logic [31:0]   settings,
  output logic [AW-1:0] ptr,
  output logic [LW-1:0] cnt,
  output dir_e          dir
);
  logic mode_q;
  logic [1:0] dir_q;
  logic wr_ok, launch;

  assign wr_ok  = we && !busy;
  assign launch = wr_ok && (addr == OFF_CTL) && (wdata[1:0] == 2'b11) && !wdata[3];
  assign dir    = dir_e'(dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settings <= '0;
      ptr      <= '0;
      cnt      <= '0;
      dir_q    <= '0;
      mode_q   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (addr)
          OFF_SET: settings <= wdata;
          OFF_PTR: ptr      <= wdata[AW-1:0];
          OFF_CNT: cnt      <= wdata[LW-1:0];
          OFF_CTL: begin
            dir_q  <= wdata[3:2];
            mode_q <= wdata[1];
          end
          default: ;
        endcase
      end
      if (launch) busy <= 1'b1;
      else if (fin) busy <= 1'b0;
      if (step) begin
        ptr <= ptr + 1'b1;
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr)
      OFF_SET: rdata = settings;
      OFF_PTR: rdata = 32'(ptr);
      OFF_CNT: rdata = 32'(cnt);
      OFF_CTL: rdata = {28'd0, dir_q, mode_q, busy};
      default: rdata = '0;
    endcase
  end

  // R10
  always @(posedge clk) begin
    if (rst_n && busy && $past(busy) && $past(rst_n))
      frozen_settings_chk: assert ($stable(settings));
  end
endmodule

// File: rtl/sdma_clkdiv.sv
module sdma_clkdiv #(
  parameter int DIV_MAX = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int HALF_MAX = DIV_MAX / 2;
  localparam int K_MAX    = $clog2(HALF_MAX);
  localparam int CW       = $clog2(HALF_MAX) + 1;

  logic [CW-1:0] cnt, half;
  logic [2:0] k;

  assign k    = (int'(rate) > K_MAX) ? 3'(K_MAX) : rate;
  assign half = CW'(HALF_MAX >> k);
  assign tick = en && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdma_shifter.sv
module sdma_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       sdi,
  output logic       sclk,
  output logic       sdo,
  output logic       running,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [2:0] bitn;
  logic [7:0] sr_tx;

  assign sdo  = sr_tx[7];
  assign done = running && tick && sclk && (bitn == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      sclk    <= 1'b0;
      bitn    <= '0;
      sr_tx   <= '0;
      rx_byte <= '0;
    end else if (start && !running) begin
      running <= 1'b1;
      sclk    <= 1'b0;
      bitn    <= '0;
      sr_tx   <= tx_byte;
    end else if (running && tick) begin
      if (!sclk) begin
        sclk    <= 1'b1;
        rx_byte <= {rx_byte[6:0], sdi};
      end else begin
        sclk  <= 1'b0;
        sr_tx <= {sr_tx[6:0], 1'b0};
        bitn  <= bitn + 1'b1;
        if (bitn == 3'd7) running <= 1'b0;
      end
    end
  end

  // R4
  always @(posedge clk) begin
    if (rst_n && $past(rst_n) && !$stable(sdo))
      sdo_low_phase_chk: assert (!sclk);
  end
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
  import sdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int NCS     = 3,
  parameter int DIV_MAX = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [5:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_we,
  output logic [AW-1:0]  mem_req_addr,
  output logic [7:0]     mem_req_wdata,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [7:0]     mem_rsp_data,
  output logic [NCS-1:0] ser_cs_n,
  output logic           ser_sclk,
  output logic           ser_sdo,
  input  logic           ser_sdi
);
  localparam int CS_LSB = 7;

  state_e st;
  dir_e dir;
  logic busy, step, fin, last;
  logic [31:0] settings;
  logic [AW-1:0] ptr;
  logic [LW-1:0] cnt;
  logic sh_start, sh_run, sh_done, tick;
  logic [7:0] sh_tx, rx_byte;

  sdma_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .step(step), .fin(fin), .busy(busy), .settings(settings),
    .ptr(ptr), .cnt(cnt), .dir(dir)
  );

  sdma_clkdiv #(.DIV_MAX(DIV_MAX)) u_div (
    .clk(clk), .rst_n(rst_n), .en(sh_run), .rate(settings[6:4]), .tick(tick)
  );

  sdma_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .tick(tick),
    .sdi(ser_sdi), .sclk(ser_sclk), .sdo(ser_sdo), .running(sh_run),
    .done(sh_done), .rx_byte(rx_byte)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign ser_cs_n[i] = ~settings[CS_LSB+i];
  end

  assign last          = (cnt == LW'(1));
  assign mem_req_valid = (st == ST_FETCH) || (st == ST_STORE);
  assign mem_req_we    = (st == ST_STORE);
  assign mem_req_addr  = ptr;
  assign mem_req_wdata = rx_byte;
  assign mem_rsp_ready = (st == ST_WAIT);

  always_comb begin
    step     = 1'b0;
    fin      = 1'b0;
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    unique case (st)
      ST_IDLE:  if (busy) begin
        if (cnt == '0) fin = 1'b1;
        else if (dir == DIR_IN) sh_start = 1'b1;
      end
      ST_WAIT:  if (mem_rsp_valid) begin
        sh_start = 1'b1;
        sh_tx    = mem_rsp_data;
      end
      ST_SHIFT: if (sh_done && dir == DIR_OUT) begin
        step = 1'b1;
        fin  = last;
      end
      ST_STORE: if (mem_req_ready) begin
        step     = 1'b1;
        fin      = last;
        sh_start = !last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:  if (busy && cnt != '0) st <= (dir == DIR_OUT) ? ST_FETCH : ST_SHIFT;
        ST_FETCH: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) st <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          if (dir == DIR_IN) st <= ST_STORE;
          else st <= last ? ST_IDLE : ST_FETCH;
        end
        ST_STORE: if (mem_req_ready) st <= last ? ST_IDLE : ST_SHIFT;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R6
  no_store_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dir == DIR_OUT |-> !(mem_req_valid && mem_req_we));

  // R5
  zero_sdo_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dir == DIR_IN |-> !ser_sdo);

  // R11
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && st == ST_IDLE && cnt == '0 |=> !busy && !ser_sclk);
endmodule

// File: tb/tb_sdma_chan.sv
module tb_sdma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we, mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_req_addr;
  logic [7:0] mem_req_wdata, mem_rsp_data = '0;
  logic [2:0] ser_cs_n;
  logic ser_sclk, ser_sdo, ser_sdi;

  sdma_chan dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] exp_ser_q [$];
  logic [39:0] exp_mem_q [$];
  bit out_mode = 1'b0;
  int wr_cnt = 0, stalls = 0, bp_err = 0, sdo_err = 0, rises = 0;
  time t_r1, t_r2;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
      summary();
    end
  end

  // device model
  logic [7:0] dev_cur = 8'h00, cap = 8'h00;
  logic [2:0] dev_pos = 3'd0;
  int dev_idx = 0, capn = 0;
  function automatic logic [7:0] dev_byte(int i);
    return 8'((i * 37 + 5) ^ 8'hA4);
  endfunction
  assign ser_sdi = dev_cur[3'd7 - dev_pos];

  always @(posedge ser_sclk) begin
    rises++;
    if (rises == 1) t_r1 = $time;
    if (rises == 2) t_r2 = $time;
    cap = {cap[6:0], ser_sdo};
    capn++;
    if (capn == 8) begin
      capn = 0;
      if (out_mode) begin
        if (exp_ser_q.size() == 0) chk(0, "R4", "unexpected serial byte", cap, 0);
        else begin
          logic [7:0] e;
          e = exp_ser_q.pop_front();
          chk(cap == e, "R4", "serial byte", cap, e);
        end
      end else if (cap != 8'h00) sdo_err++;
    end
  end

  always @(negedge ser_sclk) begin
    dev_pos = dev_pos + 1'b1;
    if (dev_pos == 3'd0) begin
      dev_idx++;
      dev_cur = dev_byte(dev_idx);
    end
  end

  // memory model and scoreboard monitor
  bit req_pend = 0, rsp_pend = 0, stall_pend = 0;
  logic [31:0] rd_a, st_a;
  logic st_we;
  logic [7:0] st_d;
  always @(negedge clk) begin
    if (stall_pend) begin
      if (!(mem_req_valid && mem_req_addr == st_a && mem_req_we == st_we && mem_req_wdata == st_d))
        bp_err++;
      stall_pend = 0;
    end
    if (rsp_pend) mem_rsp_valid = 1'b0;
    if (req_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[rd_a[11:0]];
    end
    mem_req_ready = rst_n && (cyc % 3 != 1);
    req_pend = 0;
    rsp_pend = mem_rsp_valid && mem_rsp_ready;
    if (mem_req_valid && !mem_req_ready && rst_n) begin
      stall_pend = 1; stalls++;
      st_a = mem_req_addr; st_we = mem_req_we; st_d = mem_req_wdata;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        wr_cnt++;
        mem[mem_req_addr[11:0]] = mem_req_wdata;
        if (exp_mem_q.size() == 0) chk(0, "R5", "unexpected store", mem_req_addr, 0);
        else begin
          logic [39:0] e;
          e = exp_mem_q.pop_front();
          chk({mem_req_addr, mem_req_wdata} == e, "R5", "store addr/data",
              {mem_req_addr[23:0], mem_req_wdata}, {e[31:8], e[7:0]});
        end
      end else begin
        req_pend = 1;
        rd_a = mem_req_addr;
      end
    end
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    do begin
      @(negedge clk);
      reg_rd(6'h20, d);
    end while (d[0]);
  endtask

  task automatic dev_reset();
    dev_idx = 0; dev_pos = 3'd0; dev_cur = dev_byte(0); capn = 0; rises = 0;
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    dev_reset();
    repeat (3) @(negedge clk);
    reg_rd(6'h14, d); chk(d == 0, "R1", "settings after reset", d, 0);
    reg_rd(6'h18, d); chk(d == 0, "R1", "pointer after reset", d, 0);
    reg_rd(6'h1C, d); chk(d == 0, "R1", "count after reset", d, 0);
    reg_rd(6'h20, d); chk(d == 0, "R1", "control after reset", d, 0);
    chk(ser_cs_n == 3'b111 && !ser_sclk && !ser_sdo && !mem_req_valid, "R1", "pins after reset",
        {ser_cs_n, ser_sclk, ser_sdo, mem_req_valid}, 6'b111000);
    rst_n = 1'b1;

    // outgoing 128-byte burst, slowest clock
    reg_wr(6'h14, 32'h0880);
    reg_wr(6'h18, 32'h100);
    reg_wr(6'h1C, 32'd128);
    reg_rd(6'h14, d); chk(d == 32'h0880, "R2", "settings readback", d, 32'h0880);
    reg_rd(6'h1C, d); chk(d == 128, "R2", "count readback", d, 128);
    reg_rd(6'h24, d); chk(d == 0, "R2", "unmapped offset", d, 0);
    chk(ser_cs_n == 3'b110, "R8", "cs for 0x0880", ser_cs_n, 3'b110);
    for (int i = 0; i < 128; i++) exp_ser_q.push_back(mem[12'h100 + i]);
    out_mode = 1; dev_reset(); wr_cnt = 0;
    reg_wr(6'h20, 32'd7);
    reg_rd(6'h20, d); chk(d == 32'h7, "R3", "busy after start 7", d, 7);
    repeat (40) @(negedge clk);
    reg_wr(6'h18, 32'hDEAD);
    reg_wr(6'h14, 32'h0);
    reg_rd(6'h14, d); chk(d == 32'h0880, "R10", "settings write while busy", d, 32'h0880);
    reg_rd(6'h18, d); chk(d >= 32'h100 && d < 32'h180, "R10", "pointer write while busy", d, 32'h100);
    wait_idle();
    chk(t_r2 - t_r1 == 32 * 20, "R7", "period k=0 (cycles)", 32'((t_r2 - t_r1) / 20), 32);
    reg_rd(6'h20, d); chk(d == 32'h6, "R3", "control after completion", d, 6);
    reg_rd(6'h18, d); chk(d == 32'h180, "R9", "pointer after out", d, 32'h180);
    reg_rd(6'h1C, d); chk(d == 0, "R9", "count after out", d, 0);
    chk(exp_ser_q.size() == 0, "R4", "all bytes sent", exp_ser_q.size(), 0);
    chk(wr_cnt == 0, "R6", "stores during out transfer", wr_cnt, 0);
    chk(ser_cs_n == 3'b110, "R8", "cs held between transfers", ser_cs_n, 3'b110);

    // incoming 128-byte burst
    out_mode = 0; dev_reset(); sdo_err = 0;
    for (int i = 0; i < 128; i++) exp_mem_q.push_back({32'h400 + 32'(i), dev_byte(i)});
    reg_wr(6'h18, 32'h400);
    reg_wr(6'h1C, 32'd128);
    reg_wr(6'h20, 32'd3);
    reg_rd(6'h20, d); chk(d == 32'h3, "R3", "busy after start 3", d, 3);
    wait_idle();
    chk(exp_mem_q.size() == 0, "R5", "all bytes stored", exp_mem_q.size(), 0);
    chk(sdo_err == 0, "R5", "non-zero sdo bytes", sdo_err, 0);
    chk(mem[12'h47F] == dev_byte(127), "R5", "last stored byte", mem[12'h47F], dev_byte(127));
    reg_rd(6'h18, d); chk(d == 32'h480, "R9", "pointer after in", d, 32'h480);
    chk(stalls > 0 && bp_err == 0, "R12", "held requests (errors)", bp_err, 0);

    // faster clock, no chip select
    reg_wr(6'h14, 32'h0820);
    chk(ser_cs_n == 3'b111, "R8", "cs for 0x0820", ser_cs_n, 3'b111);
    reg_wr(6'h18, 32'h200);
    reg_wr(6'h1C, 32'd4);
    for (int i = 0; i < 4; i++) exp_ser_q.push_back(mem[12'h200 + i]);
    out_mode = 1; dev_reset();
    reg_wr(6'h20, 32'd7);
    wait_idle();
    chk(t_r2 - t_r1 == 8 * 20, "R7", "period k=2 (cycles)", 32'((t_r2 - t_r1) / 20), 8);
    chk(exp_ser_q.size() == 0, "R4", "short burst sent", exp_ser_q.size(), 0);

    // zero count
    out_mode = 0; dev_reset();
    reg_wr(6'h1C, 32'd0);
    reg_wr(6'h20, 32'd3);
    reg_rd(6'h20, d); chk(d[0] == 1'b1, "R11", "busy first cycle", d[0], 1);
    @(negedge clk);
    reg_rd(6'h20, d); chk(d[0] == 1'b0, "R11", "busy second cycle", d[0], 0);
    repeat (20) @(negedge clk);
    chk(rises == 0, "R11", "serial clock edges", rises, 0);
    chk(bp_err == 0, "R12", "final hold errors", bp_err, 0);
    summary();
  end
endmodule